// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is a single output cell of a small programmable logic device. It takes one sum-of-products result from the logic array and shapes it into a tri-state pin. It also returns one feedback bit to the array. A three-bit configuration word selects the cell's behaviour in three ways:

- The pin either follows the sum directly or follows a D flip-flop that samples the sum on each rising clock edge.
- The pin is either true or inverted.
- The feedback bit is either the flip-flop's state or the value that is actually present on the pin.

Product terms from the array drive the pin's enable, a global synchronous set and a global asynchronous clear. A synchronous active-high reset stands in for the power-on reset and leaves the flip-flop at zero.

The pin is modelled as a value plus a drive enable. A separate input carries whatever an external driver puts on the pin while the cell is not driving it.

Top module: `pld_macrocell`

## Requirements
- R1: With cfg[1]=1 the output is combinatorial: pin_out equals sum_in when cfg[0]=1 and equals the inverse of sum_in when cfg[0]=0, with no clock edge needed.
- R2: With cfg[1]=0 the output is registered. The flip-flop state Q takes sum_in at each rising clk edge. pin_out equals Q when cfg[0]=1 and equals the inverse of Q when cfg[0]=0.
- R3: If preset_term is 1 at a rising clk edge and clear_term is 0, Q is 1 after that edge, whatever the value of sum_in.
- R4: While clear_term is 1, Q is 0 at once, without waiting for a clock edge.
- R5: When clear_term and preset_term are both 1 at a clock edge, Q stays 0.
- R6: pin_oe is 1 exactly when oe_term is 1. Otherwise the pin is left undriven.
- R7: With cfg[2]=0 and cfg[1]=0, fb_out equals Q, whatever the values of oe_term and pin_in.
- R8: In every other configuration, fb_out is the resolved pin: pin_out while pin_oe=1 and pin_in while pin_oe=0. A disabled cell therefore acts as a dedicated input.
- R9: A rising clk edge with rst=1 leaves Q at 0. After reset the pin therefore reads 1 in registered active-low mode and 0 in registered active-high mode.
- R10: cfg[2] has no effect on pin_out when cfg[1]=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the flip-flop |
| rst | input | 1 | Synchronous active-high power-on reset pulse |
| cfg | input | 3 | Configuration bits {C2,C1,C0} |
| sum_in | input | 1 | Sum-of-products result from the array |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global asynchronous clear term |
| pin_in | input | 1 | Level put on the pin by an external driver |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin drive enable; 0 means high impedance |
| fb_out | output | 1 | Feedback bit returned to the logic array |

## Verification
Combinatorial results (R1, R6, R8, R10) are due in the same cycle as the stimulus. The bench drives these at a falling edge and samples one time unit later. Flip-flop results (R2, R3, R5, R9) are due one rising edge after the stimulus. The bench drives those at a falling edge, checks that the pin has not yet moved, and samples again just after the next rising edge. The asynchronous clear (R4) is asserted half a cycle away from any edge and checked before the next edge arrives, which shows that it does not wait for the clock.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int CFG_W = 3;

  typedef struct packed {
    logic registered;   // pin follows the flip-flop
    logic active_high;  // no inversion on the pin
    logic reg_fb;       // feedback from flip-flop instead of pin
  } mc_mode_t;
endpackage

// File: rtl/mc_cfg_decode.sv
module mc_cfg_decode
  import mc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output mc_mode_t         mode
);
  always_comb begin
    mode.registered  = ~cfg[1];
    mode.active_high = cfg[0];
    mode.reg_fb      = ~cfg[2] & ~cfg[1];
  end
endmodule

// File: rtl/mc_dff.sv
module mc_dff #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic set_sync,
  input  logic clr_async,
  output logic q
);
  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async)     q <= 1'b0;
    else if (rst)      q <= RESET_VAL;
    else if (set_sync) q <= 1'b1;
    else               q <= d;
  end
endmodule

// File: rtl/mc_outsel.sv
module mc_outsel
  import mc_pkg::*;
(
  input  mc_mode_t mode,
  input  logic     sum,
  input  logic     q,
  input  logic     oe,
  input  logic     pin_in,
  output logic     pin_out,
  output logic     pin_oe,
  output logic     fb
);
  logic core;
  logic resolved;

  always_comb begin
    core     = mode.registered ? q : sum;
    pin_out  = mode.active_high ? core : ~core;
    pin_oe   = oe;
    resolved = oe ? pin_out : pin_in;
    fb       = mode.reg_fb ? q : resolved;
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             sum_in,
  input  logic             oe_term,
  input  logic             preset_term,
  input  logic             clear_term,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out
);
  mc_mode_t mode;
  logic     q_state;

  mc_cfg_decode u_dec (
    .cfg  (cfg),
    .mode (mode)
  );

  mc_dff #(.RESET_VAL(1'b0)) u_ff (
    .clk       (clk),
    .rst       (rst),
    .d         (sum_in),
    .set_sync  (preset_term),
    .clr_async (clear_term),
    .q         (q_state)
  );

  mc_outsel u_sel (
    .mode    (mode),
    .sum     (sum_in),
    .q       (q_state),
    .oe      (oe_term),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb      (fb_out)
  );
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cfg,
  input logic       sum_in,
  input logic       oe_term,
  input logic       preset_term,
  input logic       clear_term,
  input logic       pin_in,
  input logic       pin_out,
  input logic       pin_oe,
  input logic       fb_out,
  input logic       q_state
);
  // R1
  comb_path_chk: assert property (@(posedge clk) disable iff (rst)
    cfg[1] |-> pin_out == (cfg[0] ? sum_in : ~sum_in));

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!preset_term && !clear_term) |=> (clear_term || q_state == $past(sum_in)));

  // R3
  preset_set_chk: assert property (@(posedge clk) disable iff (rst)
    (preset_term && !clear_term) |=> (q_state || clear_term));

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clear_term |-> !q_state);

  // R6
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pin_oe == oe_term);

  // R7
  reg_fb_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg[2:1] == 2'b00) |-> fb_out == q_state);

  // R8
  pin_fb_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg[2] || cfg[1]) && !pin_oe) |-> fb_out == pin_in);

  // R9
  reset_low_chk: assert property (@(posedge clk) disable iff (clear_term)
    rst |=> !q_state);
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg         (cfg),
  .sum_in      (sum_in),
  .oe_term     (oe_term),
  .preset_term (preset_term),
  .clear_term  (clear_term),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .fb_out      (fb_out),
  .q_state     (q_state)
);

// File: tb/sim_pld_macrocell.sv
module sim_pld_macrocell;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] cfg;
  logic       sum_in, oe_term, preset_term, clear_term, pin_in;
  logic       pin_out, pin_oe, fb_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pld_macrocell u0 (
    .clk(clk), .rst(rst), .cfg(cfg), .sum_in(sum_in), .oe_term(oe_term),
    .preset_term(preset_term), .clear_term(clear_term), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic check(input logic got, input logic exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  // R9: reset leaves Q low; pin level set by polarity
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; cfg = 3'b000; sum_in = 1'b1; oe_term = 1'b1;
    after_edge();
    after_edge();
    check(pin_out, 1'b1, "R9 active-low after reset");
    @(negedge clk);
    cfg = 3'b001;
    #1;
    check(pin_out, 1'b0, "R9 active-high after reset");
    @(negedge clk);
    rst = 1'b0; sum_in = 1'b0;
  endtask

  // R1, R10: combinatorial path with both polarities and both C2 values
  task automatic t_comb();
    for (int c2 = 0; c2 < 2; c2++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        sum_in = 1'(s);
        cfg = {1'(c2), 2'b11};
        #1;
        check(pin_out, 1'(s), "R1 comb active-high");
        cfg = {1'(c2), 2'b10};
        #1;
        check(pin_out, ~1'(s), "R10 comb active-low with C2 varied");
      end
    end
  endtask

  // R2: registered output waits for the clock edge
  task automatic t_reg();
    @(negedge clk);
    cfg = 3'b001; sum_in = 1'b0;
    after_edge();
    @(negedge clk);
    sum_in = 1'b1;
    #1;
    check(pin_out, 1'b0, "R2 no change before edge");
    after_edge();
    check(pin_out, 1'b1, "R2 captured on edge");
    @(negedge clk);
    cfg = 3'b000;
    #1;
    check(pin_out, 1'b0, "R2 active-low shows inverse of Q");
  endtask

  // R3: preset sets Q regardless of sum
  task automatic t_preset();
    @(negedge clk);
    cfg = 3'b001; sum_in = 1'b0;
    after_edge();
    check(pin_out, 1'b0, "R3 setup Q=0");
    @(negedge clk);
    preset_term = 1'b1;
    after_edge();
    check(pin_out, 1'b1, "R3 preset to 1");
    @(negedge clk);
    preset_term = 1'b0;
  endtask

  // R4: clear acts without a clock edge
  task automatic t_clear();
    @(negedge clk);
    cfg = 3'b001; sum_in = 1'b1;
    after_edge();
    @(negedge clk);
    clear_term = 1'b1;
    #1;
    check(pin_out, 1'b0, "R4 immediate clear");
    after_edge();
    check(pin_out, 1'b0, "R4 held through edge");
    @(negedge clk);
    clear_term = 1'b0;
    after_edge();
    check(pin_out, 1'b1, "R2 capture resumes after clear");
  endtask

  // R5: clear overrides preset
  task automatic t_both();
    @(negedge clk);
    cfg = 3'b001; sum_in = 1'b0;
    after_edge();
    @(negedge clk);
    preset_term = 1'b1; clear_term = 1'b1;
    after_edge();
    check(pin_out, 1'b0, "R5 clear beats preset");
    @(negedge clk);
    preset_term = 1'b0; clear_term = 1'b0;
  endtask

  // R6: drive enable follows the enable term
  task automatic t_oe();
    @(negedge clk);
    oe_term = 1'b0;
    #1;
    check(pin_oe, 1'b0, "R6 disabled");
    oe_term = 1'b1;
    #1;
    check(pin_oe, 1'b1, "R6 enabled");
  endtask

  // R7, R8: feedback source selection
  task automatic t_fb();
    @(negedge clk);
    cfg = 3'b001; sum_in = 1'b0;
    after_edge();
    @(negedge clk);
    oe_term = 1'b0; pin_in = 1'b1;
    #1;
    check(fb_out, 1'b0, "R7 register feedback ignores pin_in");
    cfg = 3'b101;
    #1;
    check(fb_out, 1'b1, "R8 disabled pin feeds back pin_in");
    oe_term = 1'b1;
    #1;
    check(fb_out, 1'b0, "R8 enabled pin feeds back pin_out");
    cfg = 3'b011; sum_in = 1'b1; oe_term = 1'b0; pin_in = 1'b0;
    #1;
    check(fb_out, 1'b0, "R8 comb mode as dedicated input");
    oe_term = 1'b1;
    #1;
    check(fb_out, 1'b1, "R8 comb mode feeds back driven value");
  endtask

  initial begin
    rst = 1'b1; cfg = 3'b000; sum_in = 1'b0; oe_term = 1'b1;
    preset_term = 1'b0; clear_term = 1'b0; pin_in = 1'b0;
    t_reset();
    t_comb();
    t_reg();
    t_preset();
    t_clear();
    t_both();
    t_oe();
    t_fb();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule